// File: doc/BRIEF.md
# Multi-Rate Bisection Quantizer

This block turns a normalized log-domain difference value and its sign into an adaptive differential PCM code. It serves one of four coding rates, 16, 24, 32 or 40 kbit/s. For each rate it keeps its own table of decision thresholds. A fixed-length bisection over that table finds the magnitude level of the input. The level, shifted up by the level count when the sign is negative, then addresses one of two output tables for the chosen rate. The first holds the transmitted code. The second holds an alternate index, which a decoder uses for synchronous coding adjustment.

A search begins with a one-cycle `start`. The block performs one bisection step per clock. The number of steps depends only on the rate and there is no early exit. A one-cycle `done` then presents the result, and `code` holds that result until the next search completes. All tables are loaded through a simple write port.

Top module: `adpcm_bisect_quant`

## Requirements
- R1: While reset is held and just after it is released, `busy` and `done` are 0 and `code` is 0.
- R2: A `start` sampled while the block is idle makes `busy` rise. With rate select 0, 1, 2 or 3 (16, 24, 32 or 40 kbit/s), `done` is high exactly 1, 2, 3 or 4 cycles after that edge, for a single cycle, with `busy` low in that cycle.
- R3: The level count N is 2, 4, 8 or 16 for rate select 0 to 3. Thresholds for levels 1 to N-1 are 12-bit signed. For a non-decreasing threshold table, the level found is the largest m in 1..N-1 with input >= threshold[m], and 0 when there is no such m.
- R4: When the sign input is not all-ones, the output is entry `level` of the selected rate's table.
- R5: When the sign input is all-ones, the output is entry `level + N` of the selected rate's table.
- R6: With mode 0 the output comes from the code table. With mode 1 it comes from the sync-adjustment table. Both are indexed the same way.
- R7: A `start` raised while `busy` is high is ignored. Changes to rate, mode, input or sign during a search do not alter the result of that search.
- R8: A `start` given in the same cycle as `done` is accepted, and the next search begins on that edge.
- R9: An input equal to a threshold counts as reaching it. An input below every threshold gives level 0. An input at or above the top threshold gives level N-1.
- R10: Table writes use a select: 0 for thresholds at address rate*16+m, 1 for the code table and 2 for the sync table, both at address rate*32+index. The code and sync tables keep the low 5 bits of the write data. A write to one rate's entry leaves the other rates' results unchanged.
- R11: `code` changes only on the edge that raises `done`, and keeps its value between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| rate | input | 2 | Rate select, 0..3 for 16..40 kbit/s |
| mode | input | 1 | 0 = code table, 1 = sync-adjustment table |
| diff_log | input | 12 | Signed normalized log difference |
| diff_sign | input | 12 | All-ones = negative, otherwise positive |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| code | output | 5 | Result, held between searches |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 2 | 0 thresholds, 1 code table, 2 sync table |
| tbl_addr | input | 7 | Table write address |
| tbl_wdata | input | 12 | Table write data |

## Verification
Two things can happen in the same cycle: the result strobe of one search and the acceptance of the next `start`. The bench provokes this by waiting only for `busy` to drop before issuing each search, so every search starts in the cycle where the previous one signals `done`. A scoreboard checks each `done` against the code it expects and against the cycle it expects, both computed by a linear scan of the bench's own threshold list. If the new search disturbed the old result, or was not taken on that edge, the code or the timing of the next comparison would be wrong.

// File: rtl/adpcm_bisect_pkg.sv
package adpcm_bisect_pkg;

  localparam int RATE_W     = 2;
  localparam int MAX_LEVELS = 16;
  localparam int LVL_W      = $clog2(MAX_LEVELS);

  typedef enum logic [1:0] {
    RATE_16K = 2'd0,
    RATE_24K = 2'd1,
    RATE_32K = 2'd2,
    RATE_40K = 2'd3
  } rate_e;

  // magnitude levels for a rate: 2, 4, 8, 16
  function automatic int levels_for(input logic [RATE_W-1:0] r);
    return 2 << r;
  endfunction

  // bisection steps for a rate: 1..4
  function automatic int steps_for(input logic [RATE_W-1:0] r);
    return int'(r) + 1;
  endfunction

  // output-table index: negative differences use the upper half
  function automatic int out_index(input int level, input logic neg,
                                   input logic [RATE_W-1:0] r);
    return neg ? level + levels_for(r) : level;
  endfunction

endpackage

// File: rtl/adpcm_bisect_tables.sv
module adpcm_bisect_tables
  import adpcm_bisect_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [RATE_W+LVL_W:0] wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [RATE_W+LVL_W-1:0] thr_addr,
  output logic [DW-1:0]        thr_data,
  input  logic [RATE_W+LVL_W:0] out_addr,
  input  logic                 out_sel,
  output logic [CW-1:0]        out_data
);
  localparam int TAW      = RATE_W + LVL_W;
  localparam int THR_DEP  = 1 << TAW;
  localparam int OUT_DEP  = 1 << (TAW + 1);
  localparam int N_BANKS  = 2;

  logic [DW-1:0] thr_mem [THR_DEP];

  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == 2'd0) thr_mem[wr_addr[TAW-1:0]] <= wr_data;
  end
  assign thr_data = thr_mem[thr_addr];

  logic [CW-1:0] bank_rd [N_BANKS];

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    logic [CW-1:0] mem [OUT_DEP];
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel == 2'(g + 1)) mem[wr_addr] <= wr_data[CW-1:0];
    end
    assign bank_rd[g] = mem[out_addr];
  end

  assign out_data = bank_rd[out_sel];

endmodule

// File: rtl/adpcm_bisect_search.sv
module adpcm_bisect_search
  import adpcm_bisect_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  input  logic [DW-1:0]     din,
  output logic              accept,
  output logic              busy,
  output logic              last_step,
  output logic [LVL_W-1:0]  level,
  output logic [RATE_W-1:0] rate_hold,
  output logic [RATE_W+LVL_W-1:0] thr_addr,
  input  logic [DW-1:0]     thr_data
);
  localparam int CNT_W = $clog2(steps_for(2'(MAX_LEVELS > 0 ? 3 : 0)) + 1);

  logic [LVL_W-1:0]  a_q;
  logic [LVL_W:0]    b_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DW-1:0]     din_q;
  logic [RATE_W-1:0] rate_q;
  logic              busy_q;

  logic [LVL_W-1:0]  mid;
  logic              reach;
  logic [LVL_W-1:0]  next_a;
  logic [LVL_W:0]    next_b;

  always_comb begin
    mid    = LVL_W'(({1'b0, a_q} + b_q) >> 1);
    reach  = $signed(din_q) >= $signed(thr_data);
    next_a = reach ? mid : a_q;
    next_b = reach ? b_q : {1'b0, mid};
  end

  assign accept    = start && !busy_q;
  assign last_step = busy_q && (cnt_q == CNT_W'(1));
  assign busy      = busy_q;
  assign level     = next_a;
  assign rate_hold = rate_q;
  assign thr_addr  = {rate_q, mid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      din_q  <= '0;
      rate_q <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      a_q    <= '0;
      b_q    <= (LVL_W+1)'(levels_for(rate));
      cnt_q  <= CNT_W'(steps_for(rate));
      din_q  <= din;
      rate_q <= rate;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      a_q   <= next_a;
      b_q   <= next_b;
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_step) busy_q <= 1'b0;
    end
  end

  // interval stays non-empty during a search
  p_interval_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, a_q} < b_q));

  // probe strictly inside the interval
  p_probe_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (mid > a_q && {1'b0, mid} < b_q));

  // step counter never exceeds the rate's step count while busy
  p_step_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && int'(cnt_q) <= steps_for(rate_q)));

  // latched operands hold through a search
  p_operands_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(rate_q) && $stable(din_q)));

endmodule

// File: rtl/adpcm_bisect_quant.sv
module adpcm_bisect_quant
  import adpcm_bisect_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  input  logic              mode,
  input  logic [DW-1:0]     diff_log,
  input  logic [DW-1:0]     diff_sign,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     code,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [RATE_W+LVL_W:0] tbl_addr,
  input  logic [DW-1:0]     tbl_wdata
);
  localparam int IDX_W = LVL_W + 1;

  logic                   accept;
  logic                   last_step;
  logic [LVL_W-1:0]       level;
  logic [RATE_W-1:0]      rate_q;
  logic [RATE_W+LVL_W-1:0] thr_addr;
  logic [DW-1:0]          thr_data;
  logic [IDX_W-1:0]       idx;
  logic [CW-1:0]          out_data;
  logic                   neg_q;
  logic                   mode_q;
  logic                   done_q;
  logic [CW-1:0]          code_q;

  adpcm_bisect_search #(.DW(DW)) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rate      (rate),
    .din       (diff_log),
    .accept    (accept),
    .busy      (busy),
    .last_step (last_step),
    .level     (level),
    .rate_hold (rate_q),
    .thr_addr  (thr_addr),
    .thr_data  (thr_data)
  );

  assign idx = IDX_W'(out_index(int'(level), neg_q, rate_q));

  adpcm_bisect_tables #(.DW(DW), .CW(CW)) u_tables (
    .clk      (clk),
    .wr_en    (tbl_we),
    .wr_sel   (tbl_sel),
    .wr_addr  (tbl_addr),
    .wr_data  (tbl_wdata),
    .thr_addr (thr_addr),
    .thr_data (thr_data),
    .out_addr ({rate_q, idx}),
    .out_sel  (mode_q),
    .out_data (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        neg_q  <= &diff_sign;
        mode_q <= mode;
      end
      if (last_step) code_q <= out_data;
    end
  end

  assign done = done_q;
  assign code = code_q;

  // start taken when idle raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // done only follows a busy cycle and finds the block idle
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // done is a single-cycle pulse unless a one-step search restarts
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && rate == RATE_16K)) |=> !done);

  // result holds outside the done edge
  p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(code));

  // the output index stays within 2N while a search runs
  p_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(idx) < 2 * levels_for(rate_q)));

endmodule

// File: tb/sim_adpcm_bisect_quant.sv
module sim_adpcm_bisect_quant;
  localparam int DW = 12;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] rate = '0;
  logic mode = 1'b0;
  logic [DW-1:0] diff_log = '0;
  logic [DW-1:0] diff_sign = '0;
  logic busy, done;
  logic [CW-1:0] code;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic [6:0] tbl_addr = '0;
  logic [DW-1:0] tbl_wdata = '0;

  always #4 clk = ~clk;

  adpcm_bisect_quant #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rate(rate), .mode(mode),
    .diff_log(diff_log), .diff_sign(diff_sign), .busy(busy), .done(done),
    .code(code), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pushes = 0;
  int dones = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [CW-1:0] last_code = '0;

  int thr  [4][16];
  int ctab [4][32];
  int stab [4][32];

  int    q_code [$];
  int    q_cyc  [$];
  string q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nlev(input int r); return 2 << r; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_addr = 7'(addr); tbl_wdata = DW'(data);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // linear-scan reference
  function automatic int expect_out(input int r, input bit md, input int d, input bit neg);
    int lv = 0;
    for (int m = 1; m < nlev(r); m++) if (d >= thr[r][m]) lv = m;
    if (neg) lv = lv + nlev(r);
    return md ? stab[r][lv] : ctab[r][lv];
  endfunction

  task automatic run(input int r, input bit md, input int d, input logic [DW-1:0] s,
                     input string tag);
    while (busy) @(negedge clk);
    start = 1'b1; rate = 2'(r); mode = md; diff_log = DW'(d); diff_sign = s;
    q_code.push_back(expect_out(r, md, d, &s));
    q_cyc.push_back(cyc + 1 + r + 1);
    q_tag.push_back(tag);
    pushes++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: pop and compare at each done
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        dones++;
        if (q_code.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
        else begin
          int ec, et;
          string tg;
          ec = q_code.pop_front(); et = q_cyc.pop_front(); tg = q_tag.pop_front();
          chk(int'(code) == ec, tg, int'(code), ec);
          chk(cyc == et, "R2 done latency", cyc, et);
          chk(!busy, "R2 busy low at done", int'(busy), 0);
        end
        last_code = code;
      end else begin
        chk(code == last_code, "R11 code held", int'(code), int'(last_code));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'({busy, done}), 0);
    chk(code == '0, "R1 reset code", int'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && code == '0, "R1 after release",
        int'({busy, done, code}), 0);

    // R10 table load
    for (int r = 0; r < 4; r++) begin
      for (int m = 1; m < nlev(r); m++) begin
        thr[r][m] = -1000 + m * (2000 / nlev(r)) + r;
        wr(0, r * 16 + m, thr[r][m]);
      end
      for (int i = 0; i < 2 * nlev(r); i++) begin
        ctab[r][i] = (i * 3 + r) & (2 * nlev(r) - 1);
        stab[r][i] = (i * 5 + 1) & (2 * nlev(r) - 1);
        wr(1, r * 32 + i, ctab[r][i]);
        wr(2, r * 32 + i, stab[r][i]);
      end
    end
    mon_on = 1'b1;

    // R3 R4 R5 R6 R9 sweep; back-to-back starts land on done cycles (R8)
    for (int r = 0; r < 4; r++) begin
      for (int md = 0; md < 2; md++) begin
        run(r, md[0], -2048, '0, "R9 below all");
        run(r, md[0], 2047, '1, "R9 above all");
        for (int m = 1; m < nlev(r); m++) begin
          run(r, md[0], thr[r][m] - 1, '0, "R4 just below");
          run(r, md[0], thr[r][m], '0, "R9 equal threshold");
          run(r, md[0], thr[r][m] + 1, '1, "R5 negative");
          run(r, md[0], thr[r][m], 12'h7FF, "R4 non-all-ones sign");
        end
      end
    end

    // R7: start while busy is ignored
    while (busy) @(negedge clk);
    run(3, 1'b0, thr[3][9], '1, "R7 original search kept");
    start = 1'b1; rate = 2'd0; mode = 1'b1; diff_log = DW'(-2048); diff_sign = '0;
    @(negedge clk);
    diff_log = DW'(2047);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy, "R7 no extra search", int'(busy), 0);

    // R8: explicit start in the done cycle
    run(2, 1'b0, thr[2][5], '0, "R8 first");
    while (!done) @(negedge clk);
    run(1, 1'b1, thr[1][2], '1, "R8 second accepted on done");

    // R10: rewrite one rate-0 entry, rate 1 unaffected
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    ctab[0][0] = 3;
    wr(1, 0, 7);
    ctab[0][0] = 7 & 31;
    run(0, 1'b0, -2048, '0, "R10 rewritten entry");
    run(1, 1'b0, -2048, '0, "R10 other rate unchanged");

    // R11: hold across idle with changing inputs
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    rate = 2'd3; diff_log = 12'h123; mode = 1'b1;
    repeat (5) @(negedge clk);

    chk(q_code.size() == 0, "R2 all results seen", q_code.size(), 0);
    chk(dones == pushes, "R7 done count", dones, pushes);
    finish_run();
  end

endmodule